// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block turns a stream of 10-bit parallel words into a single serial line. It runs on a bit clock that is twelve times the word rate. Every word becomes a frame of twelve bit slots: a leading marker bit, the ten payload bits with the least significant bit first, and a trailing marker bit. A receiver that finds the stop-then-start edge between two frames can recover word alignment at any time, for example after a cable has been plugged in while the link is running.

The block keeps its own frame position. It raises `word_take` for one bit-clock cycle per frame, and the source word on `data_in` is captured at the end of that cycle. The line stays undriven until a settling interval of `LOCK_WORDS` frame periods has passed since reset or since the enable was last deasserted. The line-enable flag `ser_oe` shows when the line is driven. While it is low, `ser_out` is held at 0 and the pad driver around the block keeps the line in high impedance.

Top module: `ser_framer_tx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `ser_oe`, `ser_out` and `word_take` are all 0.
- R2: While enabled, `word_take` is high for exactly one cycle in every 12, first in the 12th cycle after reset or enable is released (cycle index 11, counting from 0).
- R3: Only the value of `data_in` at the clock edge that ends a `word_take` cycle is transmitted. Its value in any other cycle has no effect on the line.
- R4: A driven frame places its bits in slot order 0..11 as follows: slot 0 = 1 (start), slots 1..10 = payload bits 0..9, slot 11 = 0 (stop).
- R5: A word captured at the end of cycle 12n+11 after release is sent in cycles 12(n+2) to 12(n+2)+11.
- R6: `ser_oe` is 0 during cycles 0 to 12·`LOCK_WORDS`−1 after release and becomes 1 in cycle 12·`LOCK_WORDS`.
- R7: `ser_out` is 0 in every cycle in which `ser_oe` is 0.
- R8: Raising `en_n` clears `ser_oe` at the next clock edge, holds `word_take` at 0, discards the lock progress, and on release restarts the full R6 interval.
- R9: Once set, `ser_oe` stays 1 for as long as `rst` and `en_n` stay low.
- R10: `ser_oe` rises only at a frame boundary, so the first driven bit is a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 12 cycles per word |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low enable; high forces the line off and restarts lock |
| data_in | input | 10 | Parallel payload word |
| word_take | output | 1 | High in the cycle whose closing edge captures `data_in` |
| ser_out | output | 1 | Serial line data, 0 while the line is off |
| ser_oe | output | 1 | Line drive enable (0 = high impedance) |

## Verification
A cycle counter since the last reset or enable release sets the timing of every result. `word_take` is due in cycle 11 of each 12, a word taken at the end of cycle 12n+11 is due on the line 13 cycles later, from cycle 12(n+2), and `ser_oe` is due in cycle 12·`LOCK_WORDS`. The reference model in the bench advances that counter at each rising edge and compares all outputs at the following falling edge. Inputs change 2 ns after a rising edge, so no comparison races a change. Each captured word is also recovered by a hunting deserializer that locks on the start bit and checks the stop bit. Enable pulses are applied both during the lock interval and after lock, and the exact off-to-on cycle is checked each time.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int unsigned DATA_W    = 10;
    localparam int unsigned FRAME_LEN = DATA_W + 2;
    localparam int unsigned SLOT_W    = $clog2(FRAME_LEN);

    localparam logic START_BIT = 1'b1;
    localparam logic STOP_BIT  = 1'b0;

    typedef logic [DATA_W-1:0] word_t;

    // bit 0 leaves the line first
    typedef struct packed {
        logic  stop;
        word_t payload;
        logic  start;
    } frame_t;

    function automatic frame_t make_frame(input word_t w);
        frame_t f;
        f.stop    = STOP_BIT;
        f.payload = w;
        f.start   = START_BIT;
        return f;
    endfunction

endpackage

// File: rtl/ser_slot_timer.sv
module ser_slot_timer
    import ser_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    output logic [SLOT_W-1:0] slot,
    output logic              wrap
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);

    assign wrap = (slot == LAST_SLOT) && !hold;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            slot <= '0;
        end else if (wrap) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

endmodule

// File: rtl/ser_lock_gate.sv
module ser_lock_gate #(
    parameter int unsigned LOCK_WORDS = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic wrap,
    output logic oe
);

    localparam int unsigned CNT_W = $clog2(LOCK_WORDS + 1);
    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(LOCK_WORDS - 1);

    logic [CNT_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            seen <= '0;
            oe   <= 1'b0;
        end else if (wrap && !oe) begin
            seen <= seen + 1'b1;
            if (seen == LAST_WAIT) begin
                oe <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ser_frame_shifter.sv
module ser_frame_shifter
    import ser_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  wrap,
    input  word_t data_in,
    output logic  line_bit
);

    word_t                in_q;
    logic [FRAME_LEN-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            in_q  <= '0;
            shreg <= '0;
        end else if (wrap) begin
            in_q  <= data_in;
            shreg <= make_frame(in_q);
        end else begin
            shreg <= {1'b0, shreg[FRAME_LEN-1:1]};
        end
    end

    assign line_bit = shreg[0];

endmodule

// File: rtl/ser_framer_tx.sv
module ser_framer_tx
    import ser_tx_pkg::*;
#(
    parameter int unsigned LOCK_WORDS = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic [DATA_W-1:0] data_in,
    output logic              word_take,
    output logic              ser_out,
    output logic              ser_oe
);

    logic [SLOT_W-1:0] slot;
    logic              wrap;
    logic              line_bit;
    logic              oe_q;

    ser_slot_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .hold (en_n),
        .slot (slot),
        .wrap (wrap)
    );

    ser_lock_gate #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
        .clk  (clk),
        .rst  (rst),
        .hold (en_n),
        .wrap (wrap),
        .oe   (oe_q)
    );

    ser_frame_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .hold     (en_n),
        .wrap     (wrap),
        .data_in  (data_in),
        .line_bit (line_bit)
    );

    assign word_take = wrap;
    assign ser_oe    = oe_q;
    assign ser_out   = oe_q & line_bit;

endmodule

// File: rtl/ser_framer_tx_chk.sv
module ser_framer_tx_chk (
    input logic clk,
    input logic rst,
    input logic en_n,
    input logic word_take,
    input logic ser_out,
    input logic ser_oe
);

    AST_TAKE_SPACING: assert property (@(posedge clk) disable iff (rst)
        word_take |=> !word_take) else $error("take spacing"); // R2

    AST_STOP_IN_LAST_SLOT: assert property (@(posedge clk) disable iff (rst)
        (ser_oe && word_take) |-> !ser_out) else $error("stop bit"); // R4

    AST_DISABLE_DROPS_OE: assert property (@(posedge clk) disable iff (rst)
        en_n |=> !ser_oe) else $error("disable"); // R8

    AST_OE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ser_oe && !en_n) |=> ser_oe) else $error("oe sticky"); // R9

    AST_OE_RISE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_oe) |-> $past(word_take)) else $error("oe boundary"); // R10

    AST_FIRST_BIT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_oe) |-> ser_out) else $error("first bit"); // R10

endmodule

bind ser_framer_tx ser_framer_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_n      (en_n),
    .word_take (word_take),
    .ser_out   (ser_out),
    .ser_oe    (ser_oe)
);

// File: tb/tb_ser_framer_tx.sv
module tb_ser_framer_tx;

    localparam int CLK_PERIOD = 10;
    localparam int LOCK       = 2048;
    localparam int FL         = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_n = 1'b0;
    logic [9:0] data_in = '0;
    logic       word_take, ser_out, ser_oe;

    ser_framer_tx #(.LOCK_WORDS(LOCK)) dut (
        .clk(clk), .rst(rst), .en_n(en_n), .data_in(data_in),
        .word_take(word_take), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // reference model: cycles since release, captured words in order
    int         t = 0;
    logic [9:0] words[$];

    always @(posedge clk) begin
        if (rst || en_n) begin
            t = 0;
            words.delete();
        end else begin
            if (t % FL == FL - 1) words.push_back(data_in);
            t = t + 1;
        end
    end

    function automatic logic exp_bit(input int tt);
        int s = tt % FL;
        int n = tt / FL - 2;
        if (s == 0) return 1'b1;
        if (s == FL - 1) return 1'b0;
        if (n < 0 || n >= words.size()) return 1'bx;
        return words[n][s-1];
    endfunction

    // data changes every cycle; only the captured value may reach the line (R3)
    int wi = 0;
    always @(posedge clk) begin
        #2;
        wi++;
        case (wi % 5)
            0: data_in <= 10'(1 << (wi % 10));
            1: data_in <= 10'h3FF;
            2: data_in <= 10'h000;
            3: data_in <= (wi % 2 == 0) ? 10'h2AA : 10'h155;
            default: data_in <= 10'($urandom);
        endcase
    end

    // per-cycle comparison and hunting deserializer
    int         ds_state = 0;
    int         ds_bits = 0;
    logic [9:0] ds_word;
    int         rec_idx = 0;
    int         rec_count = 0;
    bit         prev_oe = 0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit   e_take;
            bit   e_oe;
            logic e_out;
            e_take = (t % FL == FL - 1) && !en_n;
            e_oe   = (t >= FL * LOCK);
            e_out  = e_oe ? exp_bit(t) : 1'b0;
            if (word_take !== e_take) check(0, "R2", "word_take", word_take, e_take);
            else tests++;
            if (ser_oe !== e_oe) check(0, "R6 R9", "ser_oe", ser_oe, e_oe);
            else tests++;
            if (!e_oe) begin
                if (ser_out !== 1'b0) check(0, "R7", "ser_out while off", ser_out, 0);
                else tests++;
            end else begin
                if (ser_out !== e_out) check(0, "R4 R5", "line bit", ser_out, e_out);
                else tests++;
            end

            if (!ser_oe) begin
                ds_state = 0;
            end else begin
                if (!prev_oe) rec_idx = LOCK - 2;
                case (ds_state)
                    0: if (ser_out) begin ds_state = 1; ds_bits = 0; end
                    1: begin
                        ds_word[ds_bits] = ser_out;
                        ds_bits++;
                        if (ds_bits == 10) ds_state = 2;
                    end
                    default: begin
                        check(ser_out == 1'b0, "R4", "stop bit", ser_out, 0);
                        if (ser_out == 1'b0 && rec_idx < words.size()) begin
                            check(ds_word == words[rec_idx], "R3 R5", "recovered word",
                                  ds_word, words[rec_idx]);
                            rec_count++;
                        end
                        rec_idx++;
                        ds_state = 0;
                    end
                endcase
            end
            prev_oe = ser_oe;
        end
    end

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic check_lock_edge(input string tag);
        wait (t == FL * LOCK - 1);
        @(negedge clk);
        check(ser_oe == 1'b0, "R6", {tag, " oe before lock"}, ser_oe, 0);
        @(negedge clk);
        check(ser_oe == 1'b1, "R6", {tag, " oe at lock"}, ser_oe, 1);
        check(ser_out == 1'b1, "R10", {tag, " first bit is start"}, ser_out, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ser_oe == 0, "R1", "oe in reset", ser_oe, 0);
        check(ser_out == 0, "R1", "out in reset", ser_out, 0);
        check(word_take == 0, "R1", "take in reset", word_take, 0);
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        check(ser_oe == 0 && word_take == 0, "R1", "first cycle after reset",
              {ser_oe, word_take}, 0);

        // early enable pulse during lock: progress must be discarded (R8)
        wait (t == FL * 100 + 5);
        @(posedge clk); #2 en_n = 1'b1;
        @(posedge clk); #2 en_n = 1'b0;
        check_lock_edge("first");

        repeat (FL * 40 + 5) @(posedge clk);
        #2 en_n = 1'b1;
        @(negedge clk);
        check(ser_oe == 1'b1, "R9", "oe before disable edge", ser_oe, 1);
        @(negedge clk);
        check(ser_oe == 1'b0, "R8", "oe after disable edge", ser_oe, 0);
        check(ser_out == 1'b0, "R7", "out after disable", ser_out, 0);
        repeat (14) begin
            @(negedge clk);
            check(word_take == 1'b0, "R8", "take while disabled", word_take, 0);
        end
        @(posedge clk); #2 en_n = 1'b0;
        check_lock_edge("relock");

        repeat (FL * 30) @(posedge clk);
        @(negedge clk);
        check(rec_count >= 60, "R4", "recovered frame count", rec_count, 60);
        finish_run();
    end

endmodule